// File: doc/BRIEF.md
# Ring Oscillator Pair Comparator

This block is the digital evaluation stage behind a bank of free-running ring oscillators used as a device fingerprint. A challenge picks one disjoint pair from the bank. For a window of system clocks that software programs, the block counts the rising edges of both oscillators of that pair. It then reports one response bit that tells which oscillator of the pair ran faster. Because the two oscillators share the same die conditions, comparing them to each other removes global voltage and temperature drift, so the block applies no absolute frequency calibration.

Each oscillator input is asynchronous to the system clock. It is brought into the clock domain through a synchroniser, and only its rising transitions are counted. A start pulse latches the challenge and the window length, clears both counters and opens the window. When the window has closed and the counts have been compared, a one-cycle valid pulse presents the result. Equal counts raise a tie flag so that enrolment logic can mark the pair as unstable.

Top module: `ro_pair_cmp`

## Requirements
- R1: Challenge value k selects oscillator 2k as the first and 2k+1 as the second of the pair. A challenge of NUM_OSC/2 or above selects no oscillator, so both counts stay zero and the result is a tie.
- R2: Each oscillator input passes through a two-stage synchroniser and a rising-edge detector. A rising input first sampled at clock edge E is counted at edge E+2, if that edge lies within the window.
- R3: On valid, response is 1 when the first count is strictly greater than the second, and 0 otherwise. Response and tie hold their values until the next valid.
- R4: When the two counts are equal, tie is 1 and response is 0 on valid.
- R5: An accepted start clears both counters and latches win_len. Counting then happens on exactly W clock edges, where W is win_len, or 1 if win_len is 0. Outside the window the counters do not change.
- R6: busy is high for W+1 cycles, starting with the cycle after the accepted start edge. valid is high for exactly one cycle, W+2 cycles after the start edge, while busy is low.
- R7: While busy is high, start is ignored, and changes on challenge and win_len have no effect on the running measurement.
- R8: Each count saturates at 2^CNT_W-1 instead of wrapping.
- R9: During reset, busy, valid, response and tie are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | NUM_OSC | Raw oscillator signals, asynchronous |
| challenge | input | SEL_W | Pair index, sampled on an accepted start |
| win_len | input | WIN_W | Window length in clocks, sampled on an accepted start |
| start | input | 1 | Begins a measurement when the block is idle |
| busy | output | 1 | Measurement in progress |
| valid | output | 1 | One-cycle pulse when a result is presented |
| response | output | 1 | 1 when the first oscillator of the pair counted more edges |
| tie | output | 1 | Both counts were equal |

## Verification
The bench builds the block with six oscillators, which gives three legal pairs. This leaves challenge value 3 as an unused code, so the out-of-range selection can be tested. The counters are 4 bits wide, so a 100-clock window with fast oscillators drives both counters into saturation. In that case a wrapping counter would report a false winner, while a saturating one reports a tie. An 8-bit window register lets the bench cover the zero-length window, short windows that expose the two-cycle synchroniser latency, and windows long enough for clear frequency differences.

// File: rtl/ro_cmp_pkg.sv
package ro_cmp_pkg;

   typedef enum logic [1:0] {
      WIN_IDLE  = 2'd0,
      WIN_COUNT = 2'd1,
      WIN_CMP   = 2'd2
   } win_state_e;

   function automatic int unsigned sel_width(input int unsigned pairs);
      return (pairs > 1) ? $clog2(pairs) : 1;
   endfunction

endpackage

// File: rtl/ro_edge_sync.sv
module ro_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ro_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R2

endmodule

// File: rtl/ro_sat_counter.sv
module ro_sat_counter #(
   parameter int unsigned WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [WIDTH-1:0] count
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ro_sat_counter: WIDTH must be at least 1");
      end
   endgenerate

   localparam logic [WIDTH-1:0] CNT_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && (count != CNT_TOP)) begin
         count <= count + WIDTH'(1);
      end
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_TOP && !clr) |=> (count == CNT_TOP)); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(count)); // R5

endmodule

// File: rtl/ro_window_ctrl.sv
module ro_window_ctrl
   import ro_cmp_pkg::*;
#(
   parameter int unsigned WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIN_W-1:0] win_len,
   output logic             load,
   output logic             counting,
   output logic             compare,
   output logic             busy
);

   generate
      if (WIN_W < 1) begin : g_bad_win
         $error("ro_window_ctrl: WIN_W must be at least 1");
      end
   endgenerate

   localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

   win_state_e       state_q;
   logic [WIN_W-1:0] remain_q;

   assign load     = (state_q == WIN_IDLE) && start;
   assign counting = (state_q == WIN_COUNT);
   assign compare  = (state_q == WIN_CMP);
   assign busy     = (state_q != WIN_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= WIN_IDLE;
         remain_q <= '0;
      end else begin
         unique case (state_q)
            WIN_IDLE: begin
               if (start) begin
                  state_q  <= WIN_COUNT;
                  remain_q <= (win_len == '0) ? ONE : win_len;
               end
            end
            WIN_COUNT: begin
               if (remain_q == ONE) begin
                  state_q <= WIN_CMP;
               end else begin
                  remain_q <= remain_q - ONE;
               end
            end
            WIN_CMP: state_q <= WIN_IDLE;
            default: state_q <= WIN_IDLE;
         endcase
      end
   end

   AST_CMP_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      compare |-> $past(counting)); // R6

   AST_WINDOW_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && remain_q != ONE) |=> counting); // R7

endmodule

// File: rtl/ro_pair_cmp.sv
module ro_pair_cmp
   import ro_cmp_pkg::*;
#(
   parameter int unsigned NUM_OSC     = 8,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned WIN_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_PAIRS  = NUM_OSC / 2,
   localparam int unsigned SEL_W      = sel_width(NUM_PAIRS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OSC-1:0] osc_in,
   input  logic [SEL_W-1:0]   challenge,
   input  logic [WIN_W-1:0]   win_len,
   input  logic               start,
   output logic               busy,
   output logic               valid,
   output logic               response,
   output logic               tie
);

   generate
      if ((NUM_OSC < 2) || (NUM_OSC % 2 != 0)) begin : g_bad_osc
         $error("ro_pair_cmp: NUM_OSC must be even and at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ro_pair_cmp: CNT_W must be at least 1");
      end
   endgenerate

   logic [NUM_OSC-1:0] rise_vec;
   logic [SEL_W-1:0]   sel_q;
   logic [1:0]         pair_rise;
   logic [CNT_W-1:0]   pair_cnt [2];
   logic               load;
   logic               counting;
   logic               compare;

   for (genvar o = 0; o < NUM_OSC; o++) begin : g_sync
      ro_edge_sync #(
         .STAGES(SYNC_STAGES)
      ) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_in(osc_in[o]),
         .rise    (rise_vec[o])
      );
   end

   ro_window_ctrl #(
      .WIN_W(WIN_W)
   ) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .win_len (win_len),
      .load    (load),
      .counting(counting),
      .compare (compare),
      .busy    (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (load) begin
         sel_q <= challenge;
      end
   end

   always_comb begin
      pair_rise = 2'b00;
      for (int p = 0; p < NUM_PAIRS; p++) begin
         if (sel_q == SEL_W'(p)) begin
            pair_rise = {rise_vec[2*p+1], rise_vec[2*p]};
         end
      end
   end

   for (genvar c = 0; c < 2; c++) begin : g_cnt
      ro_sat_counter #(
         .WIDTH(CNT_W)
      ) i_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (load),
         .inc  (counting & pair_rise[c]),
         .count(pair_cnt[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         response <= 1'b0;
         tie      <= 1'b0;
      end else begin
         valid <= compare;
         if (compare) begin
            response <= (pair_cnt[0] > pair_cnt[1]);
            tie      <= (pair_cnt[0] == pair_cnt[1]);
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R6

   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !busy); // R6

   AST_TIE_LOW_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      tie |-> !response); // R4

   AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(sel_q)); // R7

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(pair_cnt[0])); // R5

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !compare |=> ($stable(response) && $stable(tie))); // R3

endmodule

// File: tb/test_ro_pair_cmp.sv
module test_ro_pair_cmp;

   localparam int NUM_OSC    = 6;
   localparam int CNT_W      = 4;
   localparam int WIN_W      = 8;
   localparam int NUM_PAIRS  = NUM_OSC / 2;
   localparam int SEL_W      = 2;
   localparam int CNT_MAX    = (1 << CNT_W) - 1;
   localparam int CLK_PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_OSC-1:0] osc_in = '0;
   logic [SEL_W-1:0]   challenge = '0;
   logic [WIN_W-1:0]   win_len = '0;
   logic               start = 1'b0;
   logic               busy, valid, response, tie;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   ro_pair_cmp #(
      .NUM_OSC(NUM_OSC), .CNT_W(CNT_W), .WIN_W(WIN_W), .SYNC_STAGES(2)
   ) i_ro_pair_cmp (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .challenge(challenge),
      .win_len(win_len), .start(start), .busy(busy), .valid(valid),
      .response(response), .tie(tie)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // oscillator generator: half period in clocks, 0 = manual level
   int half_cfg [NUM_OSC];
   int gen_req  [NUM_OSC];
   logic [NUM_OSC-1:0] man_val = '0;
   int ph       [NUM_OSC];
   int gen_seen [NUM_OSC];

   initial begin
      for (int i = 0; i < NUM_OSC; i++) begin
         half_cfg[i] = 0; gen_req[i] = 0; ph[i] = 0; gen_seen[i] = 0;
      end
   end

   always @(negedge clk) begin
      #1;
      for (int i = 0; i < NUM_OSC; i++) begin
         if (gen_seen[i] != gen_req[i]) begin
            gen_seen[i] = gen_req[i];
            ph[i] = 0;
            osc_in[i] = 1'b0;
         end else if (half_cfg[i] == 0) begin
            osc_in[i] = man_val[i];
         end else begin
            ph[i]++;
            if (ph[i] >= half_cfg[i]) begin
               ph[i] = 0;
               osc_in[i] = ~osc_in[i];
            end
         end
      end
   end

   // behavioural reference model
   logic [NUM_OSC-1:0] h1, h2, h3, pul;
   int m_state, m_a, m_b, m_rem, m_sel;
   bit e_busy, e_valid, e_resp, e_tie;

   always @(posedge clk) begin
      if (!rst_n) begin
         h1 = '0; h2 = '0; h3 = '0;
         m_state = 0; m_a = 0; m_b = 0; m_rem = 0; m_sel = 0;
         e_busy = 0; e_valid = 0; e_resp = 0; e_tie = 0;
      end else begin
         pul = h2 & ~h3;
         h3 = h2; h2 = h1; h1 = osc_in;
         e_valid = 0;
         case (m_state)
            0: if (start) begin
               m_a = 0; m_b = 0;
               m_rem = (win_len == 0) ? 1 : int'(win_len);
               m_sel = int'(challenge);
               m_state = 1;
            end
            1: begin
               if (m_sel < NUM_PAIRS) begin
                  if (pul[2*m_sel] && m_a < CNT_MAX) m_a++;
                  if (pul[2*m_sel+1] && m_b < CNT_MAX) m_b++;
               end
               if (m_rem == 1) m_state = 2;
               else m_rem--;
            end
            default: begin
               e_resp = (m_a > m_b);
               e_tie = (m_a == m_b);
               e_valid = 1;
               m_state = 0;
            end
         endcase
         e_busy = (m_state != 0);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 busy per cycle", busy, e_busy);
         check("R6 valid per cycle", valid, e_valid);
         check("R3 response per cycle", response, e_resp);
         check("R4 tie per cycle", tie, e_tie);
      end
   end

   task automatic set_osc(input int idx, input int half);
      half_cfg[idx] = half;
      gen_req[idx]++;
   endtask

   task automatic wait_idle();
      while (busy || valid) @(negedge clk);
   endtask

   // drives start for one cycle, returns cycles from the start edge to valid
   task automatic measure(input int chal, input int win, output int lat);
      @(negedge clk);
      start = 1'b1; challenge = SEL_W'(chal); win_len = WIN_W'(win);
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!valid && lat < 2000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      check("R9 busy in reset", busy, 0);
      check("R9 valid in reset", valid, 0);
      check("R9 response in reset", response, 0);
      check("R9 tie in reset", tie, 0);
      #2 rst_n = 1'b1;

      set_osc(0, 2); set_osc(1, 3);
      set_osc(2, 4); set_osc(3, 2);
      set_osc(4, 3); set_osc(5, 3);
      repeat (4) @(negedge clk);

      measure(0, 40, lat);
      check("R1 R3 pair 0 first faster response", response, 1);
      check("R6 latency W=40", lat, 42);
      wait_idle();

      measure(1, 40, lat);
      check("R3 pair 1 second faster response", response, 0);
      check("R3 pair 1 tie", tie, 0);
      wait_idle();

      measure(2, 40, lat);
      check("R4 equal oscillators tie", tie, 1);
      check("R4 equal oscillators response", response, 0);
      wait_idle();

      measure(3, 20, lat);
      check("R1 out-of-range challenge tie", tie, 1);
      wait_idle();

      measure(0, 0, lat);
      check("R5 zero window latency", lat, 3);
      wait_idle();

      measure(0, 5, lat);
      check("R5 short window latency", lat, 7);
      wait_idle();

      set_osc(0, 1); set_osc(1, 2);
      repeat (4) @(negedge clk);
      measure(0, 100, lat);
      check("R8 both counters saturate to tie", tie, 1);
      wait_idle();

      // start and challenge change mid-window are ignored
      set_osc(0, 2); set_osc(1, 3);
      repeat (4) @(negedge clk);
      @(negedge clk);
      start = 1'b1; challenge = 2'd0; win_len = 8'd30;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      repeat (5) begin @(negedge clk); lat++; end
      start = 1'b1; challenge = 2'd1; win_len = 8'd2;
      @(negedge clk); lat++;
      start = 1'b0;
      while (!valid && lat < 2000) begin @(negedge clk); lat++; end
      check("R7 restart ignored latency", lat, 32);
      check("R7 restart ignored response", response, 1);
      wait_idle();

      // synchroniser latency with single manual edges
      set_osc(0, 0); set_osc(1, 0);
      man_val = '0;
      repeat (6) @(negedge clk);
      @(negedge clk);
      start = 1'b1; challenge = 2'd0; win_len = 8'd3;
      man_val[0] = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!valid) @(negedge clk);
      check("R2 edge at start counted", response, 1);
      wait_idle();

      man_val = '0;
      repeat (6) @(negedge clk);
      @(negedge clk);
      start = 1'b1; challenge = 2'd0; win_len = 8'd3;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      man_val[0] = 1'b1;
      while (!valid) @(negedge clk);
      check("R2 edge two clocks late falls outside window", tie, 1);
      wait_idle();

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule